// File: doc/BRIEF.md
# Interleaved Dual-Port Banked RAM

This block is an on-chip memory built from 16-bit banks. The banks are grouped in even/odd pairs, and each pair forms a 32-bit module. Two ports work at the same time and do not depend on each other. Port X serves the instruction/coefficient space and port Y serves the data space. Each port carries a 20-bit address counted in 16-bit words. The address picks a module and a row within it. Address bit 0 picks either the full 32-bit pair or only the odd half.

Reads complete with zero wait states. Read data and the per-port flags are registered, so they appear after the next rising clock edge. Writes take effect at that same edge. A 2-bit half-word enable on each port lets either 16-bit half be written alone.

Both spaces may use the same module in the same cycle, although this is unsupported. When they do, the block raises a conflict flag. Port Y wins any write collision. Addresses beyond the populated banks read as zero and their writes are dropped. Each port has its own out-of-range flag for this case. Memory contents are not cleared by reset.

Top module: `ilv_dpram`

## Requirements
- R1: Both ports can read in the same cycle. A port with en=1 and an even address `a` returns {word[a+1], word[a]} on rdata after the next rising edge. Here word[n] is the 16-bit word at linear word address n, the even bank holds the low half (rdata[15:0]) and the odd bank holds the high half (rdata[31:16]).
- R2: At an even address, we[0] writes wdata[15:0] to word[a] and we[1] writes wdata[31:16] to word[a+1]. Each enable acts on its own.
- R3: At an odd address `a`, a read returns {16'h0000, word[a]}. we[0] writes wdata[15:0] to word[a], and we[1] is ignored.
- R4: A write takes effect at the edge that samples it. A read of the same location in the next cycle returns the new value.
- R5: `conflict` is 1 after an edge exactly when, at that edge, both ports were enabled and in range, and both addresses fell in the same module, where module = addr / (2*BANK_DEPTH). It is 0 otherwise.
- R6: When both ports write the same word in one cycle, the port Y data is stored.
- R7: A read returns the contents that existed before the edge, even when the other port writes that word in the same cycle.
- R8: An enabled access with addr >= NUM_BANKS*BANK_DEPTH sets that port's `oor` flag after the edge and loads zero into rdata. Its writes change no stored word.
- R9: After reset, rdata, `oor` and `conflict` are all zero.
- R10: While a port's en is 0, its rdata holds its last value, its `oor` flag is 0, and it writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset for output registers and flags |
| x_en | input | 1 | Port X access enable |
| x_addr | input | 20 | Port X word address |
| x_we | input | 2 | Port X half-word write enables |
| x_wdata | input | 32 | Port X write data |
| x_rdata | output | 32 | Port X registered read data |
| x_oor | output | 1 | Port X out-of-range flag |
| y_en | input | 1 | Port Y access enable |
| y_addr | input | 20 | Port Y word address |
| y_we | input | 2 | Port Y half-word write enables |
| y_wdata | input | 32 | Port Y write data |
| y_rdata | output | 32 | Port Y registered read data |
| y_oor | output | 1 | Port Y out-of-range flag |
| conflict | output | 1 | Both ports used one module in the previous cycle |

## Verification
The assertions are checked on every cycle. They cover the following:
- Each decoded module select is one-hot-or-zero.
- A conflict never coincides with an out-of-range flag, and it only follows a cycle in which both ports were enabled.
- Out-of-range reads show zero.
- An idle port's rdata stays stable.
- A same-word double write stores the Y data.

Data correctness can only be shown by the bench scenarios, which compare both ports against a flat word-array model. These scenarios cover:
- half-word lane selection;
- odd-address half accesses;
- read-old-data under a simultaneous write;
- dropped out-of-range writes, observed by reading the model's words back afterwards.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 32;
  localparam int HALF_W = 16;

  // Module index: word address divided by the words per module (2 banks).
  function automatic logic [ADDR_W-1:0] module_of(input logic [ADDR_W-1:0] a,
                                                  input int bank_aw);
    return a >> (bank_aw + 1);
  endfunction

  // Row within each bank of the module.
  function automatic logic [ADDR_W-1:0] row_of(input logic [ADDR_W-1:0] a,
                                               input int bank_aw);
    logic [ADDR_W-1:0] mask;
    mask = (ADDR_W'(1) << bank_aw) - ADDR_W'(1);
    return (a >> 1) & mask;
  endfunction

  // Read word assembly: full pair, or odd half only.
  function automatic logic [DATA_W-1:0] merge_read(input logic [HALF_W-1:0] even_w,
                                                   input logic [HALF_W-1:0] odd_w,
                                                   input logic half);
    return half ? {{HALF_W{1'b0}}, odd_w} : {odd_w, even_w};
  endfunction

  // Data routed to the odd bank.
  function automatic logic [HALF_W-1:0] odd_wdata(input logic [DATA_W-1:0] wd,
                                                  input logic half);
    return half ? wd[HALF_W-1:0] : wd[DATA_W-1:HALF_W];
  endfunction

  // Write enable for the odd bank.
  function automatic logic odd_we(input logic [1:0] we, input logic half);
    return half ? we[0] : we[1];
  endfunction
endpackage

// File: rtl/ilv_addr_decode.sv
module ilv_addr_decode
  import ilv_pkg::*;
#(
  parameter int NUM_MODULES = 3,
  parameter int BANK_AW     = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic [ADDR_W-1:0]      addr,
  output logic [NUM_MODULES-1:0] sel,
  output logic [BANK_AW-1:0]     row,
  output logic                   half,
  output logic                   in_range
);
  logic [ADDR_W-1:0] mod_idx;
  logic [ADDR_W-1:0] row_full;

  assign mod_idx  = module_of(addr, BANK_AW);
  assign row_full = row_of(addr, BANK_AW);
  assign row      = row_full[BANK_AW-1:0];
  assign half     = addr[0];
  assign in_range = mod_idx < ADDR_W'(NUM_MODULES);

  for (genvar m = 0; m < NUM_MODULES; m++) begin : g_sel
    assign sel[m] = en && in_range && (mod_idx == ADDR_W'(m));
  end

  // R5
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  // R10
  sel_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|sel) |-> en);
endmodule

// File: rtl/ilv_bank.sv
module ilv_bank
  import ilv_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_we,
  input  logic [AW-1:0]     a_row,
  input  logic [HALF_W-1:0] a_wd,
  output logic [HALF_W-1:0] a_rd,
  input  logic              b_we,
  input  logic [AW-1:0]     b_row,
  input  logic [HALF_W-1:0] b_wd,
  output logic [HALF_W-1:0] b_rd
);
  logic [HALF_W-1:0] mem [DEPTH];

  // Read data is the pre-edge contents; registered downstream.
  assign a_rd = mem[a_row];
  assign b_rd = mem[b_row];

  // Port b is written last, so it wins a same-row collision.
  always_ff @(posedge clk) begin
    if (a_we) mem[a_row] <= a_wd;
    if (b_we) mem[b_row] <= b_wd;
  end

  // R6
  y_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_we && b_we && a_row == b_row) |=> mem[$past(b_row)] == $past(b_wd));
endmodule

// File: rtl/ilv_port_out.sv
module ilv_port_out
  import ilv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              in_range,
  input  logic              half,
  input  logic [HALF_W-1:0] even_w,
  input  logic [HALF_W-1:0] odd_w,
  output logic [DATA_W-1:0] rdata,
  output logic              oor
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      oor   <= 1'b0;
    end else begin
      oor <= en && !in_range;
      if (en) rdata <= in_range ? merge_read(even_w, odd_w, half) : '0;
    end
  end

  // R8
  oor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oor |-> rdata == '0);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> $stable(rdata));
endmodule

// File: rtl/ilv_dpram.sv
module ilv_dpram
  import ilv_pkg::*;
#(
  parameter int NUM_BANKS  = 6,
  parameter int BANK_DEPTH = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              x_en,
  input  logic [ADDR_W-1:0] x_addr,
  input  logic [1:0]        x_we,
  input  logic [DATA_W-1:0] x_wdata,
  output logic [DATA_W-1:0] x_rdata,
  output logic              x_oor,
  input  logic              y_en,
  input  logic [ADDR_W-1:0] y_addr,
  input  logic [1:0]        y_we,
  input  logic [DATA_W-1:0] y_wdata,
  output logic [DATA_W-1:0] y_rdata,
  output logic              y_oor,
  output logic              conflict
);
  localparam int NUM_MODULES = NUM_BANKS / 2;
  localparam int BANK_AW     = $clog2(BANK_DEPTH);

  logic [NUM_MODULES-1:0] x_sel, y_sel;
  logic [BANK_AW-1:0]     x_row, y_row;
  logic                   x_half, y_half, x_inr, y_inr;

  ilv_addr_decode #(.NUM_MODULES(NUM_MODULES), .BANK_AW(BANK_AW)) u_dec_x (
    .clk(clk), .rst_n(rst_n), .en(x_en), .addr(x_addr),
    .sel(x_sel), .row(x_row), .half(x_half), .in_range(x_inr));

  ilv_addr_decode #(.NUM_MODULES(NUM_MODULES), .BANK_AW(BANK_AW)) u_dec_y (
    .clk(clk), .rst_n(rst_n), .en(y_en), .addr(y_addr),
    .sel(y_sel), .row(y_row), .half(y_half), .in_range(y_inr));

  // Lane routing shared by all modules.
  logic              x_even_lane, x_odd_lane, y_even_lane, y_odd_lane;
  logic [HALF_W-1:0] x_odd_wd, y_odd_wd;
  assign x_even_lane = x_we[0] && !x_half;
  assign y_even_lane = y_we[0] && !y_half;
  assign x_odd_lane  = odd_we(x_we, x_half);
  assign y_odd_lane  = odd_we(y_we, y_half);
  assign x_odd_wd    = odd_wdata(x_wdata, x_half);
  assign y_odd_wd    = odd_wdata(y_wdata, y_half);

  logic [HALF_W-1:0] ev_x [NUM_MODULES];
  logic [HALF_W-1:0] ev_y [NUM_MODULES];
  logic [HALF_W-1:0] od_x [NUM_MODULES];
  logic [HALF_W-1:0] od_y [NUM_MODULES];

  for (genvar m = 0; m < NUM_MODULES; m++) begin : g_mod
    ilv_bank #(.DEPTH(BANK_DEPTH)) u_even (
      .clk(clk), .rst_n(rst_n),
      .a_we(x_sel[m] && x_even_lane), .a_row(x_row), .a_wd(x_wdata[HALF_W-1:0]), .a_rd(ev_x[m]),
      .b_we(y_sel[m] && y_even_lane), .b_row(y_row), .b_wd(y_wdata[HALF_W-1:0]), .b_rd(ev_y[m]));

    ilv_bank #(.DEPTH(BANK_DEPTH)) u_odd (
      .clk(clk), .rst_n(rst_n),
      .a_we(x_sel[m] && x_odd_lane), .a_row(x_row), .a_wd(x_odd_wd), .a_rd(od_x[m]),
      .b_we(y_sel[m] && y_odd_lane), .b_row(y_row), .b_wd(y_odd_wd), .b_rd(od_y[m]));
  end

  // One-hot select OR-mux of bank read words.
  logic [HALF_W-1:0] x_even, x_odd, y_even, y_odd;
  always_comb begin
    x_even = '0; x_odd = '0; y_even = '0; y_odd = '0;
    for (int m = 0; m < NUM_MODULES; m++) begin
      if (x_sel[m]) begin
        x_even = x_even | ev_x[m];
        x_odd  = x_odd  | od_x[m];
      end
      if (y_sel[m]) begin
        y_even = y_even | ev_y[m];
        y_odd  = y_odd  | od_y[m];
      end
    end
  end

  ilv_port_out u_out_x (
    .clk(clk), .rst_n(rst_n), .en(x_en), .in_range(x_inr), .half(x_half),
    .even_w(x_even), .odd_w(x_odd), .rdata(x_rdata), .oor(x_oor));

  ilv_port_out u_out_y (
    .clk(clk), .rst_n(rst_n), .en(y_en), .in_range(y_inr), .half(y_half),
    .even_w(y_even), .odd_w(y_odd), .rdata(y_rdata), .oor(y_oor));

  // Same-module event, brought out for checking.
  logic same_module;
  assign same_module = |(x_sel & y_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) conflict <= 1'b0;
    else        conflict <= same_module;
  end

  // R5
  conflict_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> (!x_oor && !y_oor));

  // R5
  conflict_both_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> $past(x_en && y_en));
endmodule

// File: tb/ilv_dpram_bench.sv
module ilv_dpram_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_BANKS  = 6;
  localparam int DEPTH      = 256;
  localparam int TOTAL      = NUM_BANKS * DEPTH;
  localparam int NMOD       = NUM_BANKS / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        x_en = 1'b0, y_en = 1'b0;
  logic [19:0] x_addr = '0, y_addr = '0;
  logic [1:0]  x_we = '0, y_we = '0;
  logic [31:0] x_wdata = '0, y_wdata = '0;
  logic [31:0] x_rdata, y_rdata;
  logic        x_oor, y_oor, conflict;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] ref_mem [TOTAL];
  logic [31:0] exp_x = '0, exp_y = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ilv_dpram #(.NUM_BANKS(NUM_BANKS), .BANK_DEPTH(DEPTH)) u_ilv_dpram (
    .clk(clk), .rst_n(rst_n),
    .x_en(x_en), .x_addr(x_addr), .x_we(x_we), .x_wdata(x_wdata),
    .x_rdata(x_rdata), .x_oor(x_oor),
    .y_en(y_en), .y_addr(y_addr), .y_we(y_we), .y_wdata(y_wdata),
    .y_rdata(y_rdata), .y_oor(y_oor), .conflict(conflict));

  function automatic bit valid(input logic [19:0] a);
    return int'(a) < TOTAL;
  endfunction

  function automatic logic [31:0] model_read(input logic [19:0] a);
    if (!valid(a)) return 32'h0;
    if (a[0]) return {16'h0000, ref_mem[int'(a)]};
    return {ref_mem[int'(a) + 1], ref_mem[int'(a)]};
  endfunction

  function automatic bit same_mod(input logic [19:0] a, input logic [19:0] b);
    return (int'(a) / (2 * DEPTH)) == (int'(b) / (2 * DEPTH));
  endfunction

  task automatic model_write(input logic [19:0] a, input logic [1:0] we,
                             input logic [31:0] d);
    if (!valid(a)) return;
    if (a[0]) begin
      if (we[0]) ref_mem[int'(a)] = d[15:0];
    end else begin
      if (we[0]) ref_mem[int'(a)]     = d[15:0];
      if (we[1]) ref_mem[int'(a) + 1] = d[31:16];
    end
  endtask

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Drive at negedge, model at posedge, compare at next negedge.
  task automatic step(input string tag,
                      input logic xe, input logic [19:0] xa, input logic [1:0] xw, input logic [31:0] xd,
                      input logic ye, input logic [19:0] ya, input logic [1:0] yw, input logic [31:0] yd);
    logic e_xo, e_yo, e_c;
    x_en = xe; x_addr = xa; x_we = xw; x_wdata = xd;
    y_en = ye; y_addr = ya; y_we = yw; y_wdata = yd;
    if (xe) exp_x = model_read(xa);
    if (ye) exp_y = model_read(ya);
    e_xo = xe && !valid(xa);
    e_yo = ye && !valid(ya);
    e_c  = xe && ye && valid(xa) && valid(ya) && same_mod(xa, ya);
    @(posedge clk);
    if (xe) model_write(xa, xw, xd);
    if (ye) model_write(ya, yw, yd);
    @(negedge clk);
    check(tag, "x_rdata", x_rdata, exp_x);
    check(tag, "y_rdata", y_rdata, exp_y);
    check(tag, "x_oor", {31'h0, x_oor}, {31'h0, e_xo});
    check(tag, "y_oor", {31'h0, y_oor}, {31'h0, e_yo});
    check(tag, "conflict", {31'h0, conflict}, {31'h0, e_c});
  endtask

  function automatic logic [19:0] rand_addr();
    int m;
    m = $urandom_range(0, NMOD);
    if ($urandom_range(0, 15) == 0) return 20'hFFFFF;
    return 20'(m * 2 * DEPTH + $urandom_range(0, 2 * DEPTH - 1));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "x_rdata", x_rdata, 32'h0);
    check("R9", "y_rdata", y_rdata, 32'h0);
    check("R9", "flags", {29'h0, x_oor, y_oor, conflict}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: fill all storage with full-width writes on port X
    for (int a = 0; a < TOTAL; a += 2)
      step("R2", 1, 20'(a), 2'b11, {16'(a + 1) ^ 16'h5A5A, 16'(a) ^ 16'hA5A5},
           0, 20'h0, 2'b00, 32'h0);

    // R1: parallel reads of distinct modules
    step("R1", 1, 20'd6, 2'b00, 32'h0, 1, 20'(2 * DEPTH + 10), 2'b00, 32'h0);
    // R2: low half only, then high half only
    step("R2", 1, 20'd20, 2'b01, 32'hDEAD_1111, 0, 20'h0, 2'b00, 32'h0);
    step("R2", 1, 20'd20, 2'b10, 32'h2222_BEEF, 0, 20'h0, 2'b00, 32'h0);
    // R4: read the word written in the previous cycle
    step("R4", 1, 20'd20, 2'b00, 32'h0, 0, 20'h0, 2'b00, 32'h0);
    // R3: odd address write with both enables, only odd word changes
    step("R3", 1, 20'd31, 2'b11, 32'h7777_3333, 0, 20'h0, 2'b00, 32'h0);
    step("R3", 1, 20'd31, 2'b00, 32'h0, 1, 20'd30, 2'b00, 32'h0);
    step("R3", 1, 20'd32, 2'b00, 32'h0, 0, 20'h0, 2'b00, 32'h0);
    // R6: both ports write one word, Y data survives
    step("R6", 1, 20'd40, 2'b11, 32'h1111_1111, 1, 20'd40, 2'b11, 32'h2222_2222);
    step("R6", 1, 20'd40, 2'b00, 32'h0, 0, 20'h0, 2'b00, 32'h0);
    // R7: X reads while Y writes the same word: old data
    step("R7", 1, 20'd50, 2'b00, 32'h0, 1, 20'd50, 2'b11, 32'hCAFE_F00D);
    step("R7", 1, 20'd50, 2'b00, 32'h0, 0, 20'h0, 2'b00, 32'h0);
    // R5: same module, different rows; then adjacent modules
    step("R5", 1, 20'd2, 2'b00, 32'h0, 1, 20'(2 * DEPTH - 2), 2'b00, 32'h0);
    step("R5", 1, 20'(2 * DEPTH - 2), 2'b00, 32'h0, 1, 20'(2 * DEPTH), 2'b00, 32'h0);
    // R8: last valid pair, first invalid address, dropped write
    step("R8", 1, 20'(TOTAL - 2), 2'b00, 32'h0, 1, 20'(TOTAL), 2'b11, 32'h9999_9999);
    step("R8", 1, 20'(TOTAL), 2'b00, 32'h0, 1, 20'h0, 2'b00, 32'h0);
    step("R8", 1, 20'(TOTAL - 2), 2'b00, 32'h0, 1, 20'd0, 2'b00, 32'h0);
    // R10: idle ports hold data and write nothing
    step("R10", 0, 20'd60, 2'b11, 32'hFFFF_FFFF, 0, 20'd60, 2'b11, 32'hEEEE_EEEE);
    step("R10", 1, 20'd60, 2'b00, 32'h0, 0, 20'h0, 2'b00, 32'h0);

    // Constrained random mix, R1 R2 R3 R5 R6 R7 R8 R10
    for (int i = 0; i < 3000; i++) begin
      logic [19:0] xa, ya;
      xa = rand_addr();
      ya = ($urandom_range(0, 3) == 0) ? 20'(int'(xa) ^ $urandom_range(0, 7)) : rand_addr();
      step("R_mix",
           1'($urandom_range(0, 7) != 0), xa, 2'($urandom_range(0, 3)), $urandom,
           1'($urandom_range(0, 7) != 0), ya, 2'($urandom_range(0, 3)), $urandom);
    end

    // Full read-back: no stray or dropped writes anywhere (R8)
    for (int a = 0; a < TOTAL; a += 2)
      step("R8", 1, 20'(a), 2'b00, 32'h0, 0, 20'h0, 2'b00, 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule